// File: doc/BRIEF.md
# Sensor-Paced Two-Street Signal Controller

This block runs the lamps at a crossing of a main street and a cross street. Each street has one occupancy sensor. Each street's lamp is driven with a 2-bit colour code. The block is a clocked Moore machine with four phases. A street keeps its green for as long as its own sensor reports traffic. When that sensor reads empty, the lamp goes amber for exactly one clock period, and then the other street receives green.

The block is meant to be clocked by a slow enable-rate clock. At the nominal period of five seconds, each amber phase lasts five seconds. The lamp codes are decoded only from the registered phase. The current phase is also brought out so that it can be observed.

Top module: `traffic_xing_ctrl`

## Requirements
- R1: The reset input `rst` is synchronous and active high. At a clock edge where `rst` is 1, the phase becomes MAIN_GO (code 00), whatever the sensors read. While reset is held, the lamps show main green and cross red.
- R2: In MAIN_GO (00), a clock edge with `mainSense`=1 keeps the phase at MAIN_GO. `crossSense` has no effect on this.
- R3: In MAIN_GO, a clock edge with `mainSense`=0 moves the phase to MAIN_WARN (01). `crossSense` has no effect on this.
- R4: MAIN_WARN (01) lasts exactly one clock period. The next edge always moves the phase to CROSS_GO (10), for any sensor values.
- R5: In CROSS_GO (10), a clock edge with `crossSense`=1 keeps the phase at CROSS_GO. `mainSense` has no effect on this.
- R6: In CROSS_GO, a clock edge with `crossSense`=0 moves the phase to CROSS_WARN (11).
- R7: CROSS_WARN (11) lasts exactly one clock period. The next edge always moves the phase to MAIN_GO (00), for any sensor values.
- R8: The lamp codes are green=00, amber=01 and red=10. Each phase drives the following codes:

  | Phase | `mainLight` | `crossLight` |
  |-------|-------------|--------------|
  | MAIN_GO (00) | green | red |
  | MAIN_WARN (01) | amber | red |
  | CROSS_GO (10) | red | green |
  | CROSS_WARN (11) | red | amber |
- R9: Code 11 never appears on either lamp. At least one of the two lamps is red at all times.
- R10: The lamps depend only on the registered phase. A change on the sensors between clock edges leaves both lamp codes unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one period is one amber interval |
| rst | input | 1 | Synchronous active-high reset to MAIN_GO |
| mainSense | input | 1 | Main street occupancy sensor (1 = traffic present) |
| crossSense | input | 1 | Cross street occupancy sensor (1 = traffic present) |
| mainLight | output | 2 | Main street lamp code (00 green, 01 amber, 10 red) |
| crossLight | output | 2 | Cross street lamp code (00 green, 01 amber, 10 red) |
| phase | output | 2 | Current registered phase, for observation |

## Verification
The clocked properties assume that both sensors hold a known 0 or 1 at every rising edge. They also assume that reset is applied at the first edge, so the phase register never starts from an unknown value. The stimulus keeps to these assumptions: it changes sensor values only on falling edges, and it asserts reset from time zero for several cycles. The random sensor values cover every phase and input pairing. The directed runs hold each green phase for many cycles while the other street's sensor toggles.

// File: rtl/xing_pkg.sv
package xing_pkg;

  localparam int PHASE_W = 2;
  localparam int LAMP_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    MAIN_GO    = 2'b00,
    MAIN_WARN  = 2'b01,
    CROSS_GO   = 2'b10,
    CROSS_WARN = 2'b11
  } phase_e;

  typedef enum logic [LAMP_W-1:0] {
    LAMP_GREEN = 2'b00,
    LAMP_AMBER = 2'b01,
    LAMP_RED   = 2'b10
  } lamp_e;

  // strobes from the phase control to the lamp datapath
  typedef struct packed {
    logic mainGo;
    logic mainWarn;
    logic crossGo;
    logic crossWarn;
  } lamp_ctl_s;

endpackage

// File: rtl/xing_phase_ctrl.sv
module xing_phase_ctrl
  import xing_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mainSense,
  input  logic      crossSense,
  output phase_e    phaseQ,
  output lamp_ctl_s ctl
);

  phase_e phaseD;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      MAIN_GO:    phaseD = mainSense  ? MAIN_GO  : MAIN_WARN;
      MAIN_WARN:  phaseD = CROSS_GO;
      CROSS_GO:   phaseD = crossSense ? CROSS_GO : CROSS_WARN;
      CROSS_WARN: phaseD = MAIN_GO;
      default:    phaseD = MAIN_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= MAIN_GO;
    else     phaseQ <= phaseD;
  end

  // strobes are decoded from the registered phase only (Moore)
  always_comb begin
    ctl.mainGo    = (phaseQ == MAIN_GO);
    ctl.mainWarn  = (phaseQ == MAIN_WARN);
    ctl.crossGo   = (phaseQ == CROSS_GO);
    ctl.crossWarn = (phaseQ == CROSS_WARN);
  end

endmodule

// File: rtl/xing_lamp_path.sv
module xing_lamp_path
  import xing_pkg::*;
(
  input  lamp_ctl_s         ctl,
  output logic [LAMP_W-1:0] mainLight,
  output logic [LAMP_W-1:0] crossLight
);

  function automatic lamp_e pickColour(input logic go, input logic warn);
    if (go)        return LAMP_GREEN;
    else if (warn) return LAMP_AMBER;
    else           return LAMP_RED;
  endfunction

  always_comb begin
    mainLight  = pickColour(ctl.mainGo,  ctl.mainWarn);
    crossLight = pickColour(ctl.crossGo, ctl.crossWarn);
  end

endmodule

// File: rtl/traffic_xing_ctrl.sv
module traffic_xing_ctrl
  import xing_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                mainSense,
  input  logic                crossSense,
  output logic [LAMP_W-1:0]   mainLight,
  output logic [LAMP_W-1:0]   crossLight,
  output logic [PHASE_W-1:0]  phase
);

  phase_e    phaseQ;
  lamp_ctl_s ctl;

  xing_phase_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .mainSense  (mainSense),
    .crossSense (crossSense),
    .phaseQ     (phaseQ),
    .ctl        (ctl)
  );

  xing_lamp_path uLamp (
    .ctl        (ctl),
    .mainLight  (mainLight),
    .crossLight (crossLight)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/xing_ctrl_chk.sv
module xing_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mainSense,
  input logic       crossSense,
  input logic [1:0] mainLight,
  input logic [1:0] crossLight,
  input logic [1:0] phase
);

  // R1
  reset_phase_chk: assert property (@(posedge clk)
    rst |=> (phase == 2'b00));

  // R2
  main_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && mainSense) |=> (phase == 2'b00));

  // R3
  main_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && !mainSense) |=> (phase == 2'b01));

  // R4
  main_warn_once_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b01) |=> (phase == 2'b10));

  // R5
  cross_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b10 && crossSense) |=> (phase == 2'b10));

  // R6
  cross_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b10 && !crossSense) |=> (phase == 2'b11));

  // R7
  cross_warn_once_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11) |=> (phase == 2'b00));

  // R8
  lamp_map_chk: assert property (@(posedge clk) disable iff (rst)
    (phase[1] ? (mainLight == 2'b10 && crossLight == {1'b0, phase[0]})
              : (crossLight == 2'b10 && mainLight == {1'b0, phase[0]})));

  // R9
  one_red_chk: assert property (@(posedge clk) disable iff (rst)
    (mainLight != 2'b11) && (crossLight != 2'b11) &&
    (mainLight == 2'b10 || crossLight == 2'b10));

  // R10
  lamp_follows_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(phase) |-> ($stable(mainLight) && $stable(crossLight)));

endmodule

bind traffic_xing_ctrl xing_ctrl_chk uChk (
  .clk        (clk),
  .rst        (rst),
  .mainSense  (mainSense),
  .crossSense (crossSense),
  .mainLight  (mainLight),
  .crossLight (crossLight),
  .phase      (phase)
);

// File: tb/tb_traffic_xing_ctrl.sv
module tb_traffic_xing_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mainSense = 1'b0;
  logic       crossSense = 1'b0;
  logic [1:0] mainLight, crossLight, phase;

  int testsRun = 0;
  int testsFailed = 0;
  logic [1:0] modelPhase = 2'b00;
  bit finished = 1'b0;

  traffic_xing_ctrl dut (
    .clk(clk), .rst(rst), .mainSense(mainSense), .crossSense(crossSense),
    .mainLight(mainLight), .crossLight(crossLight), .phase(phase)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] expNext(input logic [1:0] p, input logic r,
                                         input logic a, input logic b);
    if (r) return 2'b00;
    case (p)
      2'b00:   return a ? 2'b00 : 2'b01;
      2'b01:   return 2'b10;
      2'b10:   return b ? 2'b10 : 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] expMain(input logic [1:0] p);
    case (p)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] expCross(input logic [1:0] p);
    case (p)
      2'b10:   return 2'b00;
      2'b11:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input logic [1:0] p, input logic r);
    if (r) return "R1";
    case (p)
      2'b00:   return "R2/R3";
      2'b01:   return "R4";
      2'b10:   return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  // one clock period: drive at falling edge, check R10 mid-cycle, then the edge result
  task automatic step(input logic r, input logic a, input logic b);
    logic [1:0] mBefore, cBefore;
    string tag;
    @(negedge clk);
    mBefore = mainLight;
    cBefore = crossLight;
    rst = r; mainSense = a; crossSense = b;
    #3;
    check("R10 main lamp steady", mainLight, mBefore);
    check("R10 cross lamp steady", crossLight, cBefore);
    tag = tagOf(modelPhase, r);
    modelPhase = expNext(modelPhase, r, a, b);
    @(posedge clk);
    #2;
    check({tag, " phase"}, phase, modelPhase);
    check("R8 main lamp", mainLight, expMain(modelPhase));
    check("R8 cross lamp", crossLight, expCross(modelPhase));
    testsRun++;
    if (mainLight == 2'b11 || crossLight == 2'b11 ||
        (mainLight != 2'b10 && crossLight != 2'b10)) begin
      testsFailed++;
      $display("FAIL R9: actual main=%b cross=%b expected no 11 and one red",
               mainLight, crossLight);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);

    // R1: reset held, sensors busy
    rst = 1'b1;
    @(posedge clk); #2;
    check("R1 phase", phase, 2'b00);
    check("R1 main lamp", mainLight, 2'b00);
    check("R1 cross lamp", crossLight, 2'b10);
    step(1'b1, 1'b0, 1'b1);

    // R2: long main green, cross sensor toggling
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'(i % 2));
    // R3, R4 (sensors high during amber)
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    // R5: long cross green, main sensor toggling
    for (int i = 0; i < 20; i++) step(1'b0, 1'(i % 2), 1'b1);
    // R6, R7 (cross sensor high during amber)
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    // R4 and R7 with all sensors low: full lap
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0);
    // R1 mid-run: go to cross green then reset
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);

    // random mix, occasional reset
    for (int i = 0; i < 600; i++)
      step(($urandom % 40) == 0, 1'($urandom), 1'($urandom));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule